// File: doc/BRIEF.md
# Protection and Auto-Restart Sequencer

This block supervises a switching LED driver and stops all switching when any fault appears. It takes three asynchronous comparator flags (supply overvoltage, current-sense overcurrent, junction over-temperature) and several synchronous flags from the switching controller. These are a gate turn-on strobe, two per-cycle flags that report continuous conduction and a maximum-length off time, and a first-switching strobe. From these it drives a global switching inhibit, a one-cycle restart request to the soft-start logic and a sticky fault-cause code.

When a fault is accepted, the inhibit holds for a fixed auto-restart interval. At the end of that interval the sequencer releases the inhibit and pulses the restart request. The over-temperature flag is the exception: it is examined only at the end of each interval, and while it is still asserted a new full interval begins. Overcurrent is blanked for a short window after each turn-on. A shorted load is found as a continuous-conduction, maximum-off-time signature that persists. Watching for that signature is only armed a set time after the first switching cycle. All intervals are parameters counted in system clock cycles. The defaults assume a 20 MHz clock.

Top module: `led_fault_supervisor`

## Requirements
- R1: While reset is asserted and after it, before any fault, `sw_inhibit` is 0, `restart_req` is 0 and `fault_cause` is 0 (none).
- R2: An asserted `ovp_raw` sets `sw_inhibit` within three clock edges of the input change (two synchronizer stages plus the state register), and `fault_cause` reads 1.
- R3: Cause codes are 1 overvoltage, 2 overcurrent, 3 over-temperature, 4 shorted load. When several faults are seen on the same cycle, the recorded code follows the priority over-temperature, overvoltage, overcurrent, shorted load.
- R4: The synchronized overcurrent flag is ignored for `BLANK_CYC` cycles after each clock edge that samples `gate_on` high. Once that window has passed, an asserted flag sets `sw_inhibit` on the next edge with cause 2.
- R5: A `gate_on` edge that samples both `ccm_cycle` and `toff_max_cycle` high starts the shorted-load signature. If the signature persists for about `SHORT_CYC` cycles of active monitoring, `sw_inhibit` sets with cause 4.
- R6: The persistence count clears whenever a `gate_on` edge samples either `ccm_cycle` or `toff_max_cycle` low. A signature broken at intervals shorter than `SHORT_CYC` never trips.
- R7: Shorted-load monitoring is off until a `first_switch` strobe is seen since the last restart. It then stays off for a further `MASK_CYC` cycles.
- R8: An accepted fault holds `sw_inhibit` high for exactly `RESTART_CYC` cycles. On the edge that clears it, `restart_req` is high for one cycle and `fault_cause` returns to 0.
- R9: Over-temperature is checked only at the end of each interval. If it is still asserted there, `sw_inhibit` stays high for another full interval and no restart request is issued.
- R10: `fault_cause` keeps the first fault's code while the inhibit is held. Faults raised during the hold do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovp_raw | input | 1 | Asynchronous supply overvoltage comparator flag |
| ocp_raw | input | 1 | Asynchronous current-sense overcurrent comparator flag |
| otp_raw | input | 1 | Asynchronous over-temperature flag, hysteresis applied upstream |
| gate_on | input | 1 | One-cycle strobe at each gate turn-on |
| ccm_cycle | input | 1 | The cycle just ended ran in continuous conduction |
| toff_max_cycle | input | 1 | The cycle just ended used the maximum off time |
| first_switch | input | 1 | Strobe at the first switching cycle after start |
| sw_inhibit | output | 1 | Global switching inhibit |
| restart_req | output | 1 | One-cycle request to begin soft start |
| fault_cause | output | 3 | Sticky cause of the fault being served |

## Verification
The assertions assume that `gate_on` and `first_switch` are single-cycle strobes and that `ccm_cycle` and `toff_max_cycle` are steady on the edge where `gate_on` is high. They also assume that the comparator flags, once synchronized, are plain levels. The stimulus changes every input only on falling clock edges. It drives the per-cycle flags in the same step as the strobe they belong to, and it never raises `gate_on` for more than one cycle. Timing checks that depend on the free-running switching pattern are written as windows around the expected trip point. Checks on the fixed paths, such as the synchronizer delay, blanking and restart interval, use exact edges.

// File: rtl/lfs_pkg.sv
// Shared types for the LED fault supervisor: fault cause codes and sequencer states.
package lfs_pkg;
    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_OVP   = 3'd1,
        CAUSE_OCP   = 3'd2,
        CAUSE_OTP   = 3'd3,
        CAUSE_SHORT = 3'd4
    } cause_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/lfs_sync.sv
// Multi-bit flop-chain synchronizer for independent asynchronous level flags.
// Assumes each bit is a slow level; no bus coherency is implied across bits.
module lfs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lfs_blank.sv
// Leading-edge blanking of the overcurrent flag.
// Assumes gate_on is a one-cycle strobe; each strobe reopens a BLANK_CYC window.
module lfs_blank #(
    parameter int unsigned BLANK_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic gate_on,
    input  logic ocp_s,
    output logic ocp_trip
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0] LOAD = BW'(BLANK_CYC);

    logic [BW-1:0] bcnt;

    // Reload the window on every turn-on and run it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   bcnt <= '0;
        else if (gate_on)    bcnt <= LOAD;
        else if (bcnt != '0) bcnt <= bcnt - 1'b1;
    end

    assign ocp_trip = ocp_s && (bcnt == '0);

    // R4: directly after a turn-on the flag can never pass the blanking gate.
    assert_blank_after_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !clr) |=> !ocp_trip);
endmodule

// File: rtl/lfs_short_det.sv
// Shorted-load detector: a persistent continuous-conduction plus maximum-off-time
// signature, sampled on each turn-on, trips after SHORT_CYC monitored cycles.
// Assumes the per-cycle flags are valid on the edge that samples gate_on high.
module lfs_short_det #(
    parameter int unsigned SHORT_CYC = 400000,
    parameter int unsigned MASK_CYC  = 240000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic gate_on,
    input  logic ccm_cycle,
    input  logic toff_max_cycle,
    input  logic first_switch,
    output logic short_hit
);
    localparam int MW = $clog2(MASK_CYC + 1);
    localparam int PW = $clog2(SHORT_CYC);
    localparam logic [MW-1:0] MASK_LOAD = MW'(MASK_CYC);
    localparam logic [PW-1:0] PLAST     = PW'(SHORT_CYC - 1);

    logic          armed;
    logic [MW-1:0] mcnt;
    logic          sig_ok;
    logic [PW-1:0] pcnt;
    logic          mon_en;

    // Arm on the first switching strobe and load the startup mask once.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed <= 1'b0;
            mcnt  <= '0;
        end else if (first_switch && !armed) begin
            armed <= 1'b1;
            mcnt  <= MASK_LOAD;
        end else if (mcnt != '0) begin
            mcnt  <= mcnt - 1'b1;
        end
    end

    assign mon_en = armed && (mcnt == '0);

    // Latch the signature seen at each turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sig_ok <= 1'b0;
        else if (gate_on)  sig_ok <= ccm_cycle && toff_max_cycle;
    end

    // Count how long the signature persists while monitoring is live.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !sig_ok || !mon_en) pcnt <= '0;
        else if (pcnt != PLAST)                  pcnt <= pcnt + 1'b1;
    end

    assign short_hit = mon_en && sig_ok && (pcnt == PLAST);

    // R7: no trip is possible before arming by the first switching strobe.
    assert_no_trip_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        short_hit |-> armed);
    // R6: a turn-on that lacks the signature removes any pending trip.
    assert_broken_sig_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !(ccm_cycle && toff_max_cycle)) |=> !short_hit);
endmodule

// File: rtl/lfs_restart_seq.sv
// Fault sequencer: accepts the first fault, holds the inhibit for RESTART_CYC
// cycles, rechecks over-temperature at the interval end, then requests restart.
// Assumes fault inputs are synchronous levels.
module lfs_restart_seq
    import lfs_pkg::*;
#(
    parameter int unsigned RESTART_CYC = 20000000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ovp,
    input  logic   ocp_trip,
    input  logic   otp,
    input  logic   short_hit,
    output logic   inhibit,
    output logic   restart_req,
    output cause_e cause
);
    localparam int CW = $clog2(RESTART_CYC);
    localparam logic [CW-1:0] LAST = CW'(RESTART_CYC - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    cause_e        first_cause;
    logic          any_fault;

    // Pick the cause to record when several faults coincide.
    always_comb begin
        if (otp)            first_cause = CAUSE_OTP;
        else if (ovp)       first_cause = CAUSE_OVP;
        else if (ocp_trip)  first_cause = CAUSE_OCP;
        else if (short_hit) first_cause = CAUSE_SHORT;
        else                first_cause = CAUSE_NONE;
    end

    assign any_fault = otp || ovp || ocp_trip || short_hit;

    // Run / halt state machine with the auto-restart interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_RUN;
            cnt         <= '0;
            cause       <= CAUSE_NONE;
            restart_req <= 1'b0;
        end else begin
            restart_req <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (any_fault) begin
                        state <= ST_HALT;
                        cnt   <= '0;
                        cause <= first_cause;
                    end
                end
                ST_HALT: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        if (!otp) begin
                            state       <= ST_RUN;
                            restart_req <= 1'b1;
                            cause       <= CAUSE_NONE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign inhibit = (state == ST_HALT);

    // R8: the halt cannot end before the interval counter reaches its end.
    assert_full_interval_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && cnt != LAST) |=> (state == ST_HALT));
    // R8: restart request lasts one cycle and follows a halt.
    assert_restart_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);
    assert_restart_after_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> ($past(state) == ST_HALT && !inhibit));
    // R9: a still-hot die at the interval end extends the halt.
    assert_otp_extends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && cnt == LAST && otp) |=> (state == ST_HALT && !restart_req));
    // R10: the recorded cause does not move during a held halt.
    assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && $past(state) == ST_HALT) |-> $stable(cause));
endmodule

// File: rtl/led_fault_supervisor.sv
// Top of the LED driver fault supervisor. Synchronizes the comparator flags,
// blanks overcurrent, detects a shorted load and sequences auto-restart.
// Assumes gate_on and first_switch are one-cycle strobes in the clk domain.
module led_fault_supervisor #(
    parameter int unsigned BLANK_CYC   = 8,
    parameter int unsigned SHORT_CYC   = 400000,
    parameter int unsigned MASK_CYC    = 240000,
    parameter int unsigned RESTART_CYC = 20000000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovp_raw,
    input  logic       ocp_raw,
    input  logic       otp_raw,
    input  logic       gate_on,
    input  logic       ccm_cycle,
    input  logic       toff_max_cycle,
    input  logic       first_switch,
    output logic       sw_inhibit,
    output logic       restart_req,
    output logic [2:0] fault_cause
);
    import lfs_pkg::*;

    logic [2:0] flags_s;
    logic       ocp_trip;
    logic       short_hit;
    cause_e     cause;

    lfs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({otp_raw, ocp_raw, ovp_raw}),
        .q     (flags_s)
    );

    lfs_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_inhibit),
        .gate_on  (gate_on),
        .ocp_s    (flags_s[1]),
        .ocp_trip (ocp_trip)
    );

    lfs_short_det #(.SHORT_CYC(SHORT_CYC), .MASK_CYC(MASK_CYC)) u_short (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr            (sw_inhibit),
        .gate_on        (gate_on),
        .ccm_cycle      (ccm_cycle),
        .toff_max_cycle (toff_max_cycle),
        .first_switch   (first_switch),
        .short_hit      (short_hit)
    );

    lfs_restart_seq #(.RESTART_CYC(RESTART_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovp         (flags_s[0]),
        .ocp_trip    (ocp_trip),
        .otp         (flags_s[2]),
        .short_hit   (short_hit),
        .inhibit     (sw_inhibit),
        .restart_req (restart_req),
        .cause       (cause)
    );

    assign fault_cause = cause;

    // R2: an inhibit only ever starts with a recorded cause.
    assert_cause_on_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_inhibit) |-> (fault_cause != 3'd0));
    // R1: without an inhibit there is no cause on the output.
    assert_idle_no_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_inhibit |-> (fault_cause == 3'd0));
endmodule

// File: tb/sim_led_fault_supervisor.sv
`timescale 1ns/1ps
module sim_led_fault_supervisor;
    localparam int BLANK = 4;
    localparam int SHORT = 40;
    localparam int MASK  = 30;
    localparam int RST_I = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovp_raw = 0, ocp_raw = 0, otp_raw = 0;
    logic gate_on = 0, ccm_cycle = 0, toff_max_cycle = 0, first_switch = 0;
    logic sw_inhibit, restart_req;
    logic [2:0] fault_cause;

    int checks = 0;
    int fails = 0;
    int restarts = 0;

    always #4 clk = ~clk;

    led_fault_supervisor #(
        .BLANK_CYC(BLANK), .SHORT_CYC(SHORT), .MASK_CYC(MASK), .RESTART_CYC(RST_I)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ovp_raw(ovp_raw), .ocp_raw(ocp_raw), .otp_raw(otp_raw),
        .gate_on(gate_on), .ccm_cycle(ccm_cycle), .toff_max_cycle(toff_max_cycle),
        .first_switch(first_switch), .sw_inhibit(sw_inhibit), .restart_req(restart_req),
        .fault_cause(fault_cause)
    );

    // Count restart pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && restart_req) restarts++;

    // Vector: {ovp, ocp, otp, expected inhibit, expected cause[2:0]}
    localparam logic [6:0] VEC [7] = '{
        7'b100_1_001, 7'b010_1_010, 7'b001_1_011, 7'b110_1_001,
        7'b101_1_011, 7'b111_1_011, 7'b000_0_000
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_restart_exact(input string req);
        // Called at the edge where the halt began.
        step(RST_I - 1);
        check(req, "inhibit before interval end", sw_inhibit, 1);
        step(1);
        check(req, "inhibit after interval", sw_inhibit, 0);
        check(req, "restart pulse", restart_req, 1);
        check(req, "cause cleared", fault_cause, 0);
        step(1);
        check(req, "restart pulse one cycle", restart_req, 0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        @(negedge clk);
        step(3);
        // R1 reset state
        check("R1", "inhibit in reset", sw_inhibit, 0);
        check("R1", "restart in reset", restart_req, 0);
        check("R1", "cause in reset", fault_cause, 0);
        rst_n = 1'b1;
        step(5);
        check("R1", "inhibit after reset", sw_inhibit, 0);
        check("R1", "cause after reset", fault_cause, 0);

        // Table walk: R2 / R3 with R8 restart timing
        for (int i = 0; i < 7; i++) begin
            logic [6:0] v;
            string tag;
            v = VEC[i];
            tag = (v[6:4] == 3'b100) ? "R2" : "R3";
            ovp_raw = v[6]; ocp_raw = v[5]; otp_raw = v[4];
            step(3);
            check(tag, "inhibit", sw_inhibit, int'(v[3]));
            check(tag, "cause", fault_cause, int'(v[2:0]));
            ovp_raw = 0; ocp_raw = 0; otp_raw = 0;
            if (v[3]) wait_restart_exact("R8");
            else step(5);
            step(3);
        end

        // R10: faults during the hold leave the cause alone
        ovp_raw = 1;
        step(3);
        ovp_raw = 0;
        check("R10", "initial cause", fault_cause, 1);
        step(5);
        ocp_raw = 1; otp_raw = 1;
        step(10);
        check("R10", "cause during hold", fault_cause, 1);
        ocp_raw = 0; otp_raw = 0;
        step(RST_I);
        check("R10", "restarted", sw_inhibit, 0);
        step(3);

        // R4: overcurrent inside the blanking window is ignored
        gate_on = 1; ocp_raw = 1;
        step(1);
        gate_on = 0;
        step(1);
        ocp_raw = 0;
        step(6);
        check("R4", "blanked pulse ignored", sw_inhibit, 0);
        // R4: held overcurrent trips right after the window
        gate_on = 1; ocp_raw = 1;
        step(1);
        gate_on = 0;
        step(4);
        check("R4", "no trip inside window", sw_inhibit, 0);
        step(1);
        check("R4", "trip after window", sw_inhibit, 1);
        check("R4", "cause overcurrent", fault_cause, 2);
        ocp_raw = 0;
        step(RST_I + 3);
        check("R4", "restarted", sw_inhibit, 0);

        // R7: signature without a first-switch strobe never trips
        for (int i = 0; i < 150; i++) begin
            gate_on = (i % 5 == 0); ccm_cycle = 1; toff_max_cycle = 1;
            step(1);
        end
        gate_on = 0;
        check("R7", "unarmed no trip", sw_inhibit, 0);

        // R6: signature broken every 20 cycles never trips
        first_switch = 1;
        step(1);
        first_switch = 0;
        for (int i = 0; i < 150; i++) begin
            gate_on = (i % 5 == 0);
            ccm_cycle = (i % 20 != 0);
            toff_max_cycle = 1;
            step(1);
        end
        gate_on = 0; ccm_cycle = 0; toff_max_cycle = 0;
        check("R6", "broken signature no trip", sw_inhibit, 0);

        // Force a restart so monitoring is disarmed again
        ovp_raw = 1;
        step(3);
        ovp_raw = 0;
        step(RST_I + 3);

        // R5 / R7: persistent signature trips only after mask plus persistence
        first_switch = 1;
        step(1);
        first_switch = 0;
        for (int i = 0; i < 100; i++) begin
            gate_on = (i % 5 == 0); ccm_cycle = 1; toff_max_cycle = 1;
            step(1);
            if (i == 55) check("R7", "masked at startup", sw_inhibit, 0);
        end
        gate_on = 0; ccm_cycle = 0; toff_max_cycle = 0;
        check("R5", "shorted load trip", sw_inhibit, 1);
        check("R5", "cause shorted load", fault_cause, 4);
        step(RST_I);
        check("R5", "restarted", sw_inhibit, 0);

        // R9: over-temperature held through the interval extends it
        r0 = restarts;
        otp_raw = 1;
        step(3);
        check("R9", "inhibit", sw_inhibit, 1);
        check("R9", "cause over-temperature", fault_cause, 3);
        step(RST_I + 10);
        check("R9", "still inhibited", sw_inhibit, 1);
        check("R9", "no restart yet", restarts - r0, 0);
        otp_raw = 0;
        step(RST_I);
        check("R9", "released at next boundary", sw_inhibit, 0);
        check("R9", "one restart", restarts - r0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule